// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single peripheral DMA channel with two buffer slots, A and B. Each slot holds a start address and a byte count. Software programs the channel through eight 32-bit registers: a configuration word, three views of one status byte (set, clear and read), and the address and count of each slot. The channel serves the slot selected by its buffer-in-use bit. It moves that slot's data one burst at a time over a request/acknowledge handshake on the memory side. When the slot is drained, the channel marks it done and switches to the other slot. Software can therefore refill one slot while the other is running, and the stream continues without a gap.

Status bits are written through separate write-one-to-set and write-one-to-clear addresses. This lets software and hardware update different bits without a read-modify-write race. Completion and error conditions raise a level interrupt, gated by an enable bit. A run bit pauses and resumes the channel between bursts. The configuration word is locked while the channel runs.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the following are all zero: the status byte, the configuration word, both slot registers, mem_req and irq.
- R2: Register offsets are selected by reg_addr[4:2]. Status bits are: bit0 run, bit1 irq enable, bit2 error, bit3 done A, bit4 start A, bit5 done B, bit6 start B, bit7 buffer-in-use (0 = A, 1 = B). A write at offset 0x04 sets every bit written as 1. A write at 0x08 clears every bit written as 1. Zero bits leave the status unchanged. Offset 0x0C reads the live status.
- R3: The configuration word at offset 0x00 is read back as written. Its bit0 drives mem_we (1 = peripheral to memory, so memory is written). Burst length in bytes is (bit2 ? 8 : 4) beats times (bit3 ? 2 : 1) bytes per beat.
- R4: While run and the start bit of the slot selected by buffer-in-use are both 1, the channel issues bursts. Each burst has mem_addr equal to the slot address and mem_len equal to the smaller of the remaining count and the burst length. After each acknowledge, the slot address (0x10 for A, 0x18 for B) rises by mem_len and the count (0x14 for A, 0x1C for B) falls by mem_len.
- R5: When a slot's count reaches zero, its start bit clears, its done bit sets and buffer-in-use moves to the other slot. If that other slot's start bit is set, it then runs.
- R6: Software that loads slot A when (buffer-in-use = 1 and start B = 1) or (buffer-in-use = 0 and start A = 0), and slot B otherwise, gets its buffers served in load order.
- R7: irq is 1 exactly when irq enable is 1 and at least one of error, done A or done B is 1. Clearing those bits deasserts it.
- R8: A write to the configuration word while run is 1 has no effect.
- R9: A slot started with a count of zero completes without any memory request.
- R10: Clearing run stops new bursts; a burst already requested still finishes. The slot address and count are held. Setting run again resumes the remaining bursts.
- R11: A slot started with a start address whose two low bits are not zero issues no request. Instead it sets error, clears run and clears that slot's start bit, and leaves its done bit and buffer-in-use unchanged.
- R12: Slot count registers hold 13 bits (maximum 0x1FFF); upper written bits read back as zero. Slot address registers hold the full 32 bits.
- R13: Once raised, mem_req stays high with mem_addr and mem_len stable until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset within the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | Burst direction, 1 = write to memory |
| mem_addr | output | 32 | Burst start address |
| mem_len | output | 5 | Burst length in bytes |
| mem_ack | input | 1 | Burst acknowledge |
| irq | output | 1 | Interrupt, level |

## Verification
The burst engine is exercised with several patterns, each aimed at a different fault:
- A slot whose count is not a whole number of bursts, which shows whether the short last burst is sized correctly.
- Two slots queued back to back with a larger burst size, which shows whether the channel hands over between slots and follows the load-choice rule.
- A zero-count slot, which separates immediate completion from a stray request.
- A long slot paused and resumed with a slow acknowledge, which shows whether the slot address and count are really held.
- A misaligned slot, which must produce an error and no traffic.

Each burst the design requests is compared against a queue of expected bursts that is built from the programmed slots. An extra burst, a missing burst or a reordered burst therefore shows up as a mismatch.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int REG_OFS_W = 5;
  localparam int ST_W      = 8;

  typedef enum logic [2:0] {
    RG_CFG    = 3'd0,
    RG_SET    = 3'd1,
    RG_CLR    = 3'd2,
    RG_STAT   = 3'd3,
    RG_A_ADDR = 3'd4,
    RG_A_CNT  = 3'd5,
    RG_B_ADDR = 3'd6,
    RG_B_CNT  = 3'd7
  } reg_sel_e;

  localparam int ST_RUN    = 0;
  localparam int ST_IE     = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_DONE_A = 3;
  localparam int ST_STRT_A = 4;
  localparam int ST_DONE_B = 5;
  localparam int ST_STRT_B = 6;
  localparam int ST_BIU    = 7;

  localparam int CFG_DIR = 0;
  localparam int CFG_BS  = 2;
  localparam int CFG_DW  = 3;

  function automatic int strt_bit(input int slot);
    return (slot == 0) ? ST_STRT_A : ST_STRT_B;
  endfunction

  function automatic int done_bit(input int slot);
    return (slot == 0) ? ST_DONE_A : ST_DONE_B;
  endfunction
endpackage

// File: rtl/dbc_slot.sv
module dbc_slot #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv,
  input  logic [LEN_W-1:0]  adv_len,
  output logic [DATA_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [DATA_W-1:0] addr_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              slot_en;

  always_comb begin
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    slot_en = ld_addr | ld_cnt | adv;
    if (adv) begin
      addr_d = addr_q + DATA_W'(adv_len);
      cnt_d  = cnt_q - CNT_W'(adv_len);
    end
    if (ld_addr) addr_d = wdata;
    if (ld_cnt)  cnt_d  = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (slot_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/dbc_status.sv
module dbc_status
  import dbc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [ST_W-1:0] wbits,
  input  logic [1:0]      done_ev,
  input  logic            err_ev,
  output logic [ST_W-1:0] st_q
);
  logic [ST_W-1:0] st_d;
  logic            st_en;

  always_comb begin
    st_d  = st_q;
    st_en = set_we | clr_we | err_ev | (|done_ev);
    for (int s = 0; s < 2; s++) begin
      if (done_ev[s]) begin
        st_d[strt_bit(s)] = 1'b0;
        st_d[done_bit(s)] = 1'b1;
        st_d[ST_BIU]      = (s == 0);
      end
    end
    if (err_ev) begin
      st_d[ST_ERR] = 1'b1;
      st_d[ST_RUN] = 1'b0;
      if (st_q[ST_BIU]) st_d[ST_STRT_B] = 1'b0;
      else              st_d[ST_STRT_A] = 1'b0;
    end
    if (set_we) st_d = st_d | wbits;
    if (clr_we) st_d = st_d & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end
endmodule

// File: rtl/dbc_engine.sv
module dbc_engine #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13,
  parameter int LEN_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [1:0]             strt,
  input  logic                   biu,
  input  logic [1:0][DATA_W-1:0] slot_addr,
  input  logic [1:0][CNT_W-1:0]  slot_cnt,
  input  logic [LEN_W-1:0]       burst_bytes,
  input  logic                   mem_ack,
  output logic                   mem_req,
  output logic [DATA_W-1:0]      mem_addr,
  output logic [LEN_W-1:0]       mem_len,
  output logic [1:0]             adv,
  output logic [LEN_W-1:0]       adv_len,
  output logic [1:0]             done_ev,
  output logic                   err_ev
);
  logic             req_q, req_d;
  logic             slot_q, slot_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             eng_en;
  logic             can_go, start_req, ack_fire;
  logic [LEN_W-1:0] req_len;

  always_comb begin
    can_go    = run && strt[biu] && !req_q;
    start_req = 1'b0;
    err_ev    = 1'b0;
    done_ev   = 2'b00;
    adv       = 2'b00;
    ack_fire  = req_q && mem_ack;
    if (slot_cnt[biu] < CNT_W'(burst_bytes)) req_len = LEN_W'(slot_cnt[biu]);
    else                                     req_len = burst_bytes;

    if (can_go) begin
      if (slot_cnt[biu] == '0)             done_ev[biu] = 1'b1;
      else if (slot_addr[biu][1:0] != 2'b00) err_ev     = 1'b1;
      else                                   start_req  = 1'b1;
    end
    if (ack_fire) begin
      adv[slot_q] = 1'b1;
      if (slot_cnt[slot_q] == CNT_W'(len_q)) done_ev[slot_q] = 1'b1;
    end

    req_d  = req_q;
    slot_d = slot_q;
    len_d  = len_q;
    eng_en = start_req | ack_fire;
    if (start_req) begin
      req_d  = 1'b1;
      slot_d = biu;
      len_d  = req_len;
    end else if (ack_fire) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      slot_q <= 1'b0;
      len_q  <= '0;
    end else if (eng_en) begin
      req_q  <= req_d;
      slot_q <= slot_d;
      len_q  <= len_d;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = slot_addr[slot_q];
  assign mem_len  = len_q;
  assign adv_len  = len_q;
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13,
  parameter int LEN_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_OFS_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    mem_addr,
  output logic [LEN_W-1:0]     mem_len,
  input  logic                 mem_ack,
  output logic                 irq
);
  logic [1:0]              rs_q;
  logic                    rst_i_n;
  logic [2:0]              sel;
  logic [DATA_W-1:0]       cfg_q;
  logic                    cfg_we;
  logic [ST_W-1:0]         st_q;
  logic [1:0][DATA_W-1:0]  slot_addr;
  logic [1:0][CNT_W-1:0]   slot_cnt;
  logic [1:0]              adv;
  logic [LEN_W-1:0]        adv_len;
  logic [1:0]              done_ev;
  logic                    err_ev;
  logic [LEN_W-1:0]        burst_bytes;
  logic                    unused_ofs;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign sel        = reg_addr[4:2];
  assign unused_ofs = ^reg_addr[1:0];

  // configuration word, locked while running
  assign cfg_we = reg_we && (sel == RG_CFG) && !st_q[ST_RUN];
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    cfg_q <= '0;
    else if (cfg_we) cfg_q <= reg_wdata;
  end

  assign burst_bytes = cfg_q[CFG_DW] ? (cfg_q[CFG_BS] ? LEN_W'(16) : LEN_W'(8))
                                     : (cfg_q[CFG_BS] ? LEN_W'(8)  : LEN_W'(4));
  assign mem_we = cfg_q[CFG_DIR];

  dbc_status u_status (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .set_we (reg_we && (sel == RG_SET)),
    .clr_we (reg_we && (sel == RG_CLR)),
    .wbits  (reg_wdata[ST_W-1:0]),
    .done_ev(done_ev),
    .err_ev (err_ev),
    .st_q   (st_q)
  );

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam logic [2:0] SEL_ADDR = 3'(4 + 2 * g);
    localparam logic [2:0] SEL_CNT  = 3'(5 + 2 * g);
    dbc_slot #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .ld_addr(reg_we && (sel == SEL_ADDR)),
      .ld_cnt (reg_we && (sel == SEL_CNT)),
      .wdata  (reg_wdata),
      .adv    (adv[g]),
      .adv_len(adv_len),
      .addr_q (slot_addr[g]),
      .cnt_q  (slot_cnt[g])
    );
  end

  dbc_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .run        (st_q[ST_RUN]),
    .strt       ({st_q[ST_STRT_B], st_q[ST_STRT_A]}),
    .biu        (st_q[ST_BIU]),
    .slot_addr  (slot_addr),
    .slot_cnt   (slot_cnt),
    .burst_bytes(burst_bytes),
    .mem_ack    (mem_ack),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_len    (mem_len),
    .adv        (adv),
    .adv_len    (adv_len),
    .done_ev    (done_ev),
    .err_ev     (err_ev)
  );

  assign irq = st_q[ST_IE] & (st_q[ST_ERR] | st_q[ST_DONE_A] | st_q[ST_DONE_B]);

  always_comb begin
    case (sel)
      RG_CFG:    reg_rdata = cfg_q;
      RG_STAT:   reg_rdata = DATA_W'(st_q);
      RG_A_ADDR: reg_rdata = slot_addr[0];
      RG_A_CNT:  reg_rdata = DATA_W'(slot_cnt[0]);
      RG_B_ADDR: reg_rdata = slot_addr[1];
      RG_B_CNT:  reg_rdata = DATA_W'(slot_cnt[1]);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbc_chk.sv
module dbc_chk
  import dbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [REG_OFS_W-1:0] reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic                 mem_req,
  input logic                 mem_ack,
  input logic [DATA_W-1:0]    mem_addr,
  input logic [LEN_W-1:0]     mem_len,
  input logic [ST_W-1:0]      st,
  input logic [DATA_W-1:0]    cfg
);
  // R2: a set write of the enable bit takes effect
  a_r2_set_ie: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr[4:2] == RG_SET && reg_wdata[ST_IE] |=> st[ST_IE]);

  // R2: a clear write of the run bit takes effect
  a_r2_clr_run: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr[4:2] == RG_CLR && reg_wdata[ST_RUN] |=> !st[ST_RUN]);

  // R8: configuration locked while running
  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr[4:2] == RG_CFG && st[ST_RUN] |=> $stable(cfg));

  // R10: a new burst starts only out of a running state
  a_r10_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(st[ST_RUN]));

  // R13: request held steady until acknowledged
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len));

  // R11: no request ever carries a misaligned address
  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind dbuf_dma_chan dbc_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_len  (mem_len),
  .st       (st_q),
  .cfg      (cfg_q)
);

// File: tb/sim_dbuf_dma_chan.sv
module sim_dbuf_dma_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] O_CFG = 5'h00, O_SET = 5'h04, O_CLR = 5'h08, O_STAT = 5'h0C;
  localparam logic [4:0] O_AA = 5'h10, O_AC = 5'h14, O_BA = 5'h18, O_BC = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr;
  logic [4:0]  mem_len;
  logic        mem_ack = 1'b0;

  typedef struct packed { logic [31:0] a; logic [4:0] l; } burst_t;
  burst_t exp_q[$];

  int checks = 0, fails = 0, cycles = 0;
  int ack_delay = 0, bursts = 0, wcnt = 0;
  bit seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_ack(mem_ack), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  // scoreboard monitor and memory model
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (!seen) begin
        seen = 1'b1;
        wcnt = ack_delay;
        if (exp_q.size() == 0) check("R4 unexpected burst", mem_addr, 32'h0);
        else begin
          burst_t e;
          e = exp_q.pop_front();
          check("R4 burst addr", mem_addr, e.a);
          check("R4 burst len", 32'(mem_len), 32'(e.l));
        end
      end
      if (wcnt == 0) begin
        mem_ack = 1'b1;
        seen = 1'b0;
        bursts++;
      end else wcnt--;
    end
  end

  task automatic push_slot(input logic [31:0] a, input int cnt, input int bl);
    logic [31:0] ad = a;
    int c = cnt;
    while (c > 0) begin
      int l = (c < bl) ? c : bl;
      exp_q.push_back({ad, 5'(l)});
      ad += 32'(l);
      c -= l;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_bits(input logic [31:0] mask);
    logic [31:0] d;
    for (int i = 0; i < 2000; i++) begin
      rd(O_STAT, d);
      if ((d & mask) == mask) break;
    end
  endtask

  // R6 load choice: 0 = slot A, 1 = slot B
  function automatic logic pick_slot(input logic [31:0] s);
    return !((s[7] && s[6]) || (!s[7] && !s[4]));
  endfunction

  initial begin
    logic [31:0] d;
    int base, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(O_STAT, d); check("R1 status", d, 32'h0);
    rd(O_CFG, d);  check("R1 cfg", d, 32'h0);
    rd(O_AC, d);   check("R1 slot A count", d, 32'h0);
    rd(O_BA, d);   check("R1 slot B addr", d, 32'h0);
    check("R1 mem_req", 32'(mem_req), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 set/clear semantics
    wr(O_SET, 32'h02); rd(O_STAT, d); check("R2 set", d, 32'h02);
    wr(O_SET, 32'h00); rd(O_STAT, d); check("R2 set zeros", d, 32'h02);
    wr(O_CLR, 32'h00); rd(O_STAT, d); check("R2 clear zeros", d, 32'h02);
    wr(O_CLR, 32'h02); rd(O_STAT, d); check("R2 clear", d, 32'h00);

    // R3 configuration
    wr(O_CFG, 32'h0000_A5F1); rd(O_CFG, d); check("R3 cfg readback", d, 32'h0000_A5F1);
    check("R3 mem_we", 32'(mem_we), 32'h1);

    // R12 register widths
    wr(O_AC, 32'hFFFF_FFFF); rd(O_AC, d); check("R12 count width", d, 32'h1FFF);
    wr(O_AA, 32'hDEAD_BEEF); rd(O_AA, d); check("R12 addr width", d, 32'hDEAD_BEEF);

    // R4 R5 R7 single slot A, short last burst, burst 4
    ack_delay = 0;
    rd(O_STAT, d); check("R6 first choice A", 32'(pick_slot(d)), 32'h0);
    wr(O_AA, 32'h100); wr(O_AC, 32'd10);
    push_slot(32'h100, 10, 4);
    wr(O_SET, 32'h13);
    wait_bits(32'h08);
    rd(O_STAT, d); check("R5 status after A", d, 32'h8B);
    check("R7 irq on done", 32'(irq), 32'h1);
    rd(O_AA, d); check("R4 A addr advanced", d, 32'h10A);
    rd(O_AC, d); check("R4 A count drained", d, 32'h0);
    check("R4 bursts A", 32'(bursts), 32'd3);
    wr(O_CLR, 32'h08); rd(O_STAT, d); check("R7 ack", d, 32'h83);
    check("R7 irq cleared", 32'(irq), 32'h0);

    // R8 config write ignored while running
    wr(O_CFG, 32'hFFFF_FFFF); rd(O_CFG, d); check("R8 cfg locked", d, 32'h0000_A5F1);

    // new config: burst 8 x 2 bytes = 16, memory read
    wr(O_CLR, 32'h01);
    wr(O_CFG, 32'h0000_123C); rd(O_CFG, d); check("R3 cfg update", d, 32'h0000_123C);
    check("R3 mem_we read", 32'(mem_we), 32'h0);

    // R5 R6 ping-pong: B then A
    ack_delay = 1;
    rd(O_STAT, d); check("R6 choice B", 32'(pick_slot(d)), 32'h1);
    wr(O_BA, 32'h200); wr(O_BC, 32'd40);
    push_slot(32'h200, 40, 16);
    wr(O_SET, 32'h40);
    rd(O_STAT, d); check("R6 choice A after B", 32'(pick_slot(d)), 32'h0);
    wr(O_AA, 32'h300); wr(O_AC, 32'd16);
    push_slot(32'h300, 16, 16);
    wr(O_SET, 32'h11);
    wait_bits(32'h28);
    repeat (4) @(negedge clk);
    rd(O_STAT, d); check("R5 both done", d, 32'hAB);
    check("R5 burst order", 32'(exp_q.size()), 32'h0);

    // R9 zero count
    wr(O_CLR, 32'h28);
    rd(O_STAT, d); check("R6 choice B zero", 32'(pick_slot(d)), 32'h1);
    base = bursts;
    wr(O_BA, 32'h600); wr(O_BC, 32'd0);
    wr(O_SET, 32'h40);
    repeat (6) @(negedge clk);
    rd(O_STAT, d); check("R9 zero completes", d, 32'h23);
    check("R9 no burst", 32'(bursts - base), 32'h0);

    // R10 pause and resume
    wr(O_CLR, 32'h20);
    ack_delay = 3;
    base = bursts;
    wr(O_AA, 32'h400); wr(O_AC, 32'd64);
    push_slot(32'h400, 64, 16);
    wr(O_SET, 32'h10);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (bursts - base >= 2) break;
    end
    wr(O_CLR, 32'h01);
    repeat (30) @(negedge clk);
    n = bursts - base;
    check("R10 paused req low", 32'(mem_req), 32'h0);
    check("R10 paused mid slot", 32'(n < 4), 32'h1);
    rd(O_AC, d); check("R10 count held", d, 32'(64 - 16 * n));
    rd(O_AA, d); check("R10 addr held", d, 32'h400 + 32'(16 * n));
    repeat (20) @(negedge clk);
    check("R10 no bursts while paused", 32'(bursts - base), 32'(n));
    wr(O_SET, 32'h01);
    wait_bits(32'h08);
    check("R10 resumed total", 32'(bursts - base), 32'd4);
    rd(O_STAT, d); check("R10 status", d, 32'h8B);

    // R11 misaligned start
    wr(O_CLR, 32'h08);
    base = bursts;
    wr(O_BA, 32'h502); wr(O_BC, 32'd8);
    wr(O_SET, 32'h40);
    repeat (6) @(negedge clk);
    rd(O_STAT, d); check("R11 error status", d, 32'h86);
    check("R11 no burst", 32'(bursts - base), 32'h0);
    check("R7 irq on error", 32'(irq), 32'h1);
    wr(O_CLR, 32'h04);
    check("R7 irq after error ack", 32'(irq), 32'h0);

    check("R4 scoreboard empty", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule